// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block drives a small set of output pins from a shared free-running timer counter. Each channel holds a compare value. When a counting cycle finds the counter equal to that value, the channel performs its programmed action on its own pin without any software step. The action can be to hold, toggle, drive low or drive high.

Channel 0 is the master channel. On its match it forces any masked subset of all pins to programmed levels. This force takes precedence over the per-channel actions in the same cycle. Pin 0 can instead show the counting-cycle enable, which serves as a counter clock out. Any pin can be switched to plain software-driven output. Every match sets a sticky flag, and software clears the flag by writing a one to it.

Each pin's compare level is held by a two-state machine with states `PIN_LO` and `PIN_HI`. Its transitions are:
- set: `PIN_LO` to `PIN_HI`, through a high action, a toggle, or a master force to 1.
- clear: `PIN_HI` to `PIN_LO`, through a low action, a toggle, or a master force to 0.
- hold: stay in the current state, when there is no match, the action is none, or the action gives the same level.

Top module: `ocu_top`

## Requirements
- R1: While reset is asserted, and after it is released, `count`, `match_flags` and every compare pin level are 0.
- R2: `count` increments by one, wrapping from 0xFFFF to 0, at every clock edge where `tick_en` is high, and holds otherwise.
- R3: A channel matches at a clock edge where `tick_en` is high and `count` equals that channel's compare value. With `tick_en` low there is no match.
- R4: On its own match, channel i applies the 2-bit action code in bits [2i+1:2i] of register 0 to pin i: 00 hold, 01 toggle, 10 drive 0, 11 drive 1. The pin shows the result after that edge.
- R5: On a channel 0 match, every pin i whose bit i is set in the mask register (address 1) takes bit i of the level register (address 2). This overrides the pin's own action at the same edge.
- R6: A match sets bit i of `match_flags`, and the bit stays set until a write to address 3 with data bit i at 1 clears it. If a set and a clear fall on the same edge, the set wins.
- R7: When bit i of the direct-enable register (address 4) is 1, pin i equals bit i of the direct-level register (address 5). Compare actions still update the hidden level, and the pin shows that level once the direct enable is cleared.
- R8: When bit 0 of address 6 is 1 and direct enable 0 is clear, pin 0 follows `tick_en` combinationally.
- R9: Compare values are written at addresses 8+i. A write to an unmapped address (7, or 12 to 15) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| tick_en | input | 1 | Counting-cycle enable for the timer counter |
| count | output | 16 | Timer counter value |
| pins | output | 4 | Output pins |
| match_flags | output | 4 | Sticky per-channel match flags |

## Verification
For each slave channel, all four action codes are swept from both starting levels, which separates toggle from set and clear. All sixteen master masks are tried with a changing level pattern while every channel matches on the same edge, which shows which pins the master owns and that it wins over the slave actions. The direct-enable and direct-level patterns are swept across a match to show that the hidden level keeps updating. A long run across the counter wrap confirms that a compare value of 0 is found after the rollover. Flag clears are tried alone and on the same edge as a match.

// File: rtl/ocu_pkg.sv
`timescale 1ns/1ps
package ocu_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    localparam int A_ACT    = 0;
    localparam int A_MASK   = 1;
    localparam int A_LEVEL  = 2;
    localparam int A_FLAGS  = 3;
    localparam int A_DIR_EN = 4;
    localparam int A_DIR_LV = 5;
    localparam int A_CLKOUT = 6;
    localparam int A_CMP0   = 8;
endpackage

// File: rtl/ocu_timebase.sv
`timescale 1ns/1ps
module ocu_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (tick_en) count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;
endmodule

// File: rtl/ocu_regs.sv
`timescale 1ns/1ps
module ocu_regs
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic [NCH-1:0]            match,
    output logic [NCH-1:0][CNT_W-1:0] cmp,
    output logic [2*NCH-1:0]          act,
    output logic [NCH-1:0]            mask,
    output logic [NCH-1:0]            level,
    output logic [NCH-1:0]            dir_en,
    output logic [NCH-1:0]            dir_lv,
    output logic                      clkout_en,
    output logic [NCH-1:0]            flags
);
    localparam int ACT_W = 2 * NCH;

    logic [NCH-1:0] clr;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return wr_en && (a == ADDR_W'(target));
    endfunction

    always_comb clr = hit(wr_addr, A_FLAGS) ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act       <= '0;
            mask      <= '0;
            level     <= '0;
            dir_en    <= '0;
            dir_lv    <= '0;
            clkout_en <= 1'b0;
            flags     <= '0;
        end else begin
            flags <= (flags & ~clr) | match;
            if (hit(wr_addr, A_ACT))    act       <= wr_data[ACT_W-1:0];
            if (hit(wr_addr, A_MASK))   mask      <= wr_data[NCH-1:0];
            if (hit(wr_addr, A_LEVEL))  level     <= wr_data[NCH-1:0];
            if (hit(wr_addr, A_DIR_EN)) dir_en    <= wr_data[NCH-1:0];
            if (hit(wr_addr, A_DIR_LV)) dir_lv    <= wr_data[NCH-1:0];
            if (hit(wr_addr, A_CLKOUT)) clkout_en <= wr_data[0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cmp[g] <= '0;
            else if (hit(wr_addr, A_CMP0 + g))  cmp[g] <= wr_data;
        end
    end
endmodule

// File: rtl/ocu_pin_fsm.sv
`timescale 1ns/1ps
module ocu_pin_fsm
    import ocu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    input  act_e act_code,
    input  logic force_fire,
    input  logic force_level,
    output logic level
);
    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_state_e;

    pin_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (force_fire) begin
            state_d = force_level ? PIN_HI : PIN_LO;
        end else if (act_fire) begin
            unique case (act_code)
                ACT_NONE:   state_d = state_q;
                ACT_TOGGLE: state_d = (state_q == PIN_HI) ? PIN_LO : PIN_HI;
                ACT_LOW:    state_d = PIN_LO;
                ACT_HIGH:   state_d = PIN_HI;
            endcase
        end
    end

    always_comb level = (state_q == PIN_HI);
endmodule

// File: rtl/ocu_top.sv
`timescale 1ns/1ps
module ocu_top
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  count,
    output logic [NCH-1:0]    pins,
    output logic [NCH-1:0]    match_flags
);
    logic [NCH-1:0][CNT_W-1:0] cmp;
    logic [2*NCH-1:0]          ctl_act;
    logic [NCH-1:0]            ctl_mask;
    logic [NCH-1:0]            ctl_level;
    logic [NCH-1:0]            dir_en;
    logic [NCH-1:0]            dir_lv;
    logic                      clkout_en;
    logic [NCH-1:0]            match;
    logic [NCH-1:0]            pin_state;

    ocu_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (count)
    );

    ocu_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .match     (match),
        .cmp       (cmp),
        .act       (ctl_act),
        .mask      (ctl_mask),
        .level     (ctl_level),
        .dir_en    (dir_en),
        .dir_lv    (dir_lv),
        .clkout_en (clkout_en),
        .flags     (match_flags)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign match[g] = tick_en && (count == cmp[g]);

        ocu_pin_fsm u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_fire    (match[g]),
            .act_code    (act_e'(ctl_act[2*g +: 2])),
            .force_fire  (match[0] && ctl_mask[g]),
            .force_level (ctl_level[g]),
            .level       (pin_state[g])
        );

        if (g == 0) begin : g_clk_pin
            assign pins[g] = dir_en[g] ? dir_lv[g]
                           : (clkout_en ? tick_en : pin_state[g]);
        end else begin : g_plain_pin
            assign pins[g] = dir_en[g] ? dir_lv[g] : pin_state[g];
        end
    end
endmodule

// File: rtl/ocu_checker.sv
`timescale 1ns/1ps
module ocu_checker
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              tick_en,
    input logic [CNT_W-1:0]  count,
    input logic [NCH-1:0]    pins,
    input logic [NCH-1:0]    match_flags,
    input logic [CNT_W-1:0]  cmp0,
    input logic [NCH-1:0]    mask,
    input logic [NCH-1:0]    level,
    input logic [NCH-1:0]    dir_en,
    input logic [NCH-1:0]    dir_lv,
    input logic              clkout_en,
    input logic [NCH-1:0]    pin_state
);
    logic [NCH-1:0] wclr;
    assign wclr = (wr_en && wr_addr == ADDR_W'(A_FLAGS)) ? wr_data[NCH-1:0] : '0;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && match_flags == '0 && pin_state == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == ($past(count) + CNT_W'(1)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    // R3
    master_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count == cmp0) |=> match_flags[0]);

    // R5
    master_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count == cmp0) |=> ((pin_state ^ $past(level)) & $past(mask)) == '0);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(match_flags) & ~$past(wclr)) & ~match_flags) == '0);

    // R7
    direct_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins ^ dir_lv) & dir_en) == '0);

    // R8
    clock_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clkout_en && !dir_en[0]) |-> pins[0] == tick_en);
endmodule

bind ocu_top ocu_checker #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_ocu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .tick_en     (tick_en),
    .count       (count),
    .pins        (pins),
    .match_flags (match_flags),
    .cmp0        (cmp[0]),
    .mask        (ctl_mask),
    .level       (ctl_level),
    .dir_en      (dir_en),
    .dir_lv      (dir_lv),
    .clkout_en   (clkout_en),
    .pin_state   (pin_state)
);

// File: tb/test_ocu_top.sv
`timescale 1ns/1ps
module test_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick_en = 1'b0;
    logic [15:0] count;
    logic [3:0]  pins;
    logic [3:0]  match_flags;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] m_cnt = '0;
    logic [15:0] m_cmp [4];
    logic [7:0]  m_act = '0;
    logic [3:0]  m_mask = '0, m_lvl = '0, m_den = '0, m_dlv = '0;
    logic [3:0]  m_pq = '0, m_flag = '0;
    logic        m_clko = 1'b0;
    logic        cur_tick = 1'b0;

    always #5 clk = ~clk;

    ocu_top i_ocu_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_en(tick_en), .count(count),
        .pins(pins), .match_flags(match_flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pins();
        logic [3:0] p;
        for (int i = 0; i < 4; i++)
            p[i] = m_den[i] ? m_dlv[i] : ((i == 0 && m_clko) ? cur_tick : m_pq[i]);
        return p;
    endfunction

    task automatic step(input logic t, input logic we, input logic [3:0] a,
                        input logic [15:0] d, input string tag);
        logic [3:0] mt;
        logic [3:0] clr;
        tick_en = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        for (int i = 0; i < 4; i++) mt[i] = t && (m_cnt == m_cmp[i]);
        for (int i = 0; i < 4; i++) begin
            if (mt[i]) begin
                case (m_act[2*i +: 2])
                    2'b01: m_pq[i] = ~m_pq[i];
                    2'b10: m_pq[i] = 1'b0;
                    2'b11: m_pq[i] = 1'b1;
                    default: ;
                endcase
            end
            if (mt[0] && m_mask[i]) m_pq[i] = m_lvl[i];
        end
        clr = (we && a == 4'd3) ? d[3:0] : 4'd0;
        m_flag = (m_flag & ~clr) | mt;
        if (t) m_cnt = m_cnt + 16'd1;
        if (we) begin
            case (a)
                4'd0: m_act  = d[7:0];
                4'd1: m_mask = d[3:0];
                4'd2: m_lvl  = d[3:0];
                4'd4: m_den  = d[3:0];
                4'd5: m_dlv  = d[3:0];
                4'd6: m_clko = d[0];
                4'd8, 4'd9, 4'd10, 4'd11: m_cmp[a - 4'd8] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
        cur_tick = t;
        check("R2 count", 32'(count), 32'(m_cnt));
        check({tag, " pins"}, 32'(pins), 32'(exp_pins()));
        check({tag, " flags"}, 32'(match_flags), 32'(m_flag));
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
        step(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 4'd0, 16'd0, tag);
    endtask

    initial begin
        #(10ns * 190000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset values while held in reset
        check("R1 count", 32'(count), 0);
        check("R1 pins", 32'(pins), 0);
        check("R1 flags", 32'(match_flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'({count, pins, match_flags}), 0);

        // R3 compare 0 matches on the first counting edge; flag clear
        step(1'b0, 1'b0, 4'd0, 16'd0, "R3 no tick no match");
        step(1'b1, 1'b0, 4'd0, 16'd0, "R3");
        wr(4'd3, 16'hFFFF, "R6");

        // R2 counting with gaps
        step(1'b1, 1'b0, 0, 0, "R2"); step(1'b0, 1'b0, 0, 0, "R2");
        step(1'b1, 1'b0, 0, 0, "R2"); step(1'b0, 1'b0, 0, 0, "R2");

        // R9 unmapped writes change nothing
        wr(4'd7, 16'hFFFF, "R9");
        wr(4'd12, 16'hFFFF, "R9");
        wr(4'd15, 16'hFFFF, "R9");
        run(3, "R9");
        for (int i = 0; i < 4; i++) wr(4'(8 + i), 16'h8000, "R9");
        wr(4'd3, 16'hF, "R6");

        // R4 sweep action codes on slave channels, two matches each
        for (int ch = 1; ch < 4; ch++) begin
            for (int code = 0; code < 4; code++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    wr(4'd0, 16'(code << (2*ch)), "R4");
                    wr(4'(8 + ch), m_cnt + 16'd2, "R4");
                    run(3, "R4 action");
                end
                wr(4'd3, 16'hF, "R6 clear");
            end
        end

        // R5 master mask sweep, every channel matches on the same edge
        wr(4'd0, 16'h0055, "R5");
        for (int m = 0; m < 16; m++) begin
            wr(4'd1, 16'(m), "R5");
            wr(4'd2, 16'(m ^ 5 ^ (m >> 1)), "R5");
            for (int i = 0; i < 4; i++) wr(4'(8 + i), m_cnt + 16'd1, "R5");
            run(2, "R5 master");
        end

        // R6 partial clear, then set and clear on the same edge
        wr(4'd3, 16'h5, "R6 partial");
        wr(4'd3, 16'hF, "R6");
        wr(4'd8, m_cnt, "R6");
        step(1'b1, 1'b1, 4'd3, 16'hFFFF, "R6 set wins");
        step(1'b0, 1'b0, 0, 0, "R6 held");

        // R7 direct-drive patterns across a match
        wr(4'd0, 16'h0055, "R7");
        wr(4'd1, 16'h0, "R7");
        for (int e = 0; e < 16; e++) begin
            wr(4'd4, 16'(e), "R7");
            wr(4'd5, 16'(~e), "R7");
            for (int i = 0; i < 4; i++) wr(4'(8 + i), m_cnt + 16'd1, "R7");
            run(2, "R7 direct");
            wr(4'd4, 16'h0, "R7 hidden level");
        end

        // R8 counter clock out on pin 0, then direct enable wins
        wr(4'd6, 16'h1, "R8");
        step(1'b1, 0, 0, 0, "R8"); step(1'b0, 0, 0, 0, "R8");
        step(1'b1, 0, 0, 0, "R8"); step(1'b1, 0, 0, 0, "R8");
        wr(4'd4, 16'h1, "R8 direct over clock");
        step(1'b1, 0, 0, 0, "R8");
        wr(4'd4, 16'h0, "R8");
        wr(4'd6, 16'h0, "R8");

        // R2 wrap, compare 0 found after rollover (R3, R4)
        wr(4'd0, 16'h0004, "R4");
        wr(4'd1, 16'h0, "R3");
        wr(4'd9, 16'h0000, "R3");
        for (int i = 0; i < 4; i++) if (i != 1) wr(4'(8 + i), 16'h1234, "R3");
        wr(4'd3, 16'hF, "R6");
        while (m_cnt != 16'hFFFF) step(1'b1, 0, 0, 0, "R2 run");
        step(1'b1, 0, 0, 0, "R2 wrap");
        step(1'b1, 0, 0, 0, "R3 after wrap");
        step(1'b0, 0, 0, 0, "R4 after wrap");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule